// File: doc/BRIEF.md
# SDRAM Refresh Scheduler with Self-Refresh Control

This block sits on the controller side of an SDRAM interface and keeps the array refreshed. A free-running interval counter produces a refresh obligation once every configured number of clock cycles. The interval is normally set to the 64 ms retention window divided by 8192, expressed in clock cycles. Before it drives an auto refresh command, the block raises a request to the main controller. It waits until the controller grants that every bank is idle. After each command it drives only no-operation cycles for a minimum gap.

If intervals expire while the grant is withheld, the block records them as a debt, capped at eight. When the grant arrives it pays the debt back to back. On request it also puts the memory into self refresh: it issues the entry command with clock enable low and keeps clock enable low until an exit request arrives. It then raises clock enable and keeps the bus quiet for the configured exit time before handing the bus back. An optional burst mode adds a full burst of refreshes just before entry and another just after exit. The timing counts and the burst option are captured while reset is held.

Top module: `sdram_refresh_sched`

## Requirements
- R1: With the grant held high, consecutive auto refresh commands are exactly `cfg_interval` cycles apart. A value of 0 is treated as 1.
- R2: Pin encodings, written as (cs_n, ras_n, cas_n, we_n, cke):
  - auto refresh is (0,0,0,1,1);
  - self refresh entry is (0,0,0,1,0);
  - every other cycle with cke high is a no-operation (0,1,1,1,1);
  - every other cycle with cke low is a deselect (1,1,1,1,0).
- R3: `ref_req` is high while the block waits for a grant. No auto refresh command appears unless `bank_idle_gnt` was high at the clock edge that launched it and cke was high in the cycle before it.
- R4: After every auto refresh, at least G no-operation cycles follow before the next refresh or entry command, where G = max(`cfg_trc`, `cfg_trp`) and 0 is treated as 1. When more work is pending and the grant is held, the next refresh comes exactly G+1 cycles after the previous one.
- R5: A pulse on `sr_enter_req` leads to the self refresh entry command. From that command on, cke stays low and the pins stay deselected until `sr_exit_req` is seen.
- R6: Cke rises in the cycle after `sr_exit_req` is sampled. Only no-operation cycles follow for T cycles, where T = `cfg_txsr` and 0 is treated as 1. Without burst mode, `busy` drops after those T cycles. With burst mode, the first refresh comes T+1 cycles after cke rises.
- R7: With `cfg_burst_en` high, exactly `BURST_N` auto refreshes are issued between an entry request and the entry command. Exactly `BURST_N` more are issued after the exit wait. Both bursts are spaced G+1 with the grant held. With `cfg_burst_en` low, no refresh is added around self refresh.
- R8: Each interval that expires while the grant is withheld adds one owed refresh, up to `OWE_MAX` (8). When the grant returns, the owed refreshes are issued back to back.
- R9: `busy` is high whenever `ref_req` is high, during each refresh and its gap, and through the whole self refresh sequence. It falls in the cycle after the last wait cycle.
- R10: While reset is low, the pins show a no-operation with cke high, and `ref_req` and `busy` are low.
- R11: The configuration inputs are sampled only while reset is low. Changing them afterwards has no effect on spacing, gaps or burst mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_interval | input | CNT_W | Cycles between scheduled refreshes |
| cfg_trc | input | CNT_W | Minimum no-operation cycles after a refresh (row cycle) |
| cfg_trp | input | CNT_W | Minimum precharge spacing before the next refresh |
| cfg_txsr | input | CNT_W | Quiet cycles after self refresh exit |
| cfg_burst_en | input | 1 | Enables full refresh bursts around self refresh |
| bank_idle_gnt | input | 1 | Main controller grants that all banks are idle |
| sr_enter_req | input | 1 | Request to enter self refresh |
| sr_exit_req | input | 1 | Request to leave self refresh |
| ref_req | output | 1 | Asks the main controller for the bank-idle grant |
| busy | output | 1 | Main controller must hold off commands |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |

## Verification
A wrong owed count appears within one interval of the grant's return, as too many or too few refreshes in the back-to-back run. A slip in the interval counter shifts the very next refresh away from its exact spacing. An off-by-one in the shared wait counter changes either the refresh-to-refresh distance or the length of the quiet run after cke rises. Burst counter errors show up as a wrong refresh count before the entry command or before `busy` falls after exit.

// File: rtl/rfs_pkg.sv
// Package: shared state encoding and pin command patterns for the refresh scheduler.
// Assumes pins are active-low command strobes plus an active-high clock enable.
package rfs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ISSUE,
        ST_WAIT,
        ST_SR_CMD,
        ST_SR_HOLD,
        ST_SR_EXIT
    } rfs_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic cke;
    } pin_cmd_t;

    localparam pin_cmd_t PINS_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, cke: 1'b1};
    localparam pin_cmd_t PINS_AREF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, cke: 1'b1};
    localparam pin_cmd_t PINS_SREN  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, cke: 1'b0};
    localparam pin_cmd_t PINS_SLEEP = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, cke: 1'b0};

endpackage

// File: rtl/rfs_interval.sv
// Interval timer and refresh debt counter.
// Produces one obligation every interval_q cycles and keeps a saturating count
// of obligations not yet served. The timer restarts from zero while 'hold' is
// high (bursts and self refresh cover the array). Assumes interval_q >= 1 and
// that 'take' is raised only while the debt is non-zero.
module rfs_interval #(
    parameter int CNT_W   = 16,
    parameter int OWE_MAX = 8,
    parameter int OW_W    = $clog2(OWE_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] interval_q,
    input  logic             hold,
    input  logic             clr,
    input  logic             take,
    output logic [OW_W-1:0]  owed
);

    logic [CNT_W-1:0] cnt;
    logic             tick;

    assign tick = !hold && (cnt == interval_q - CNT_W'(1));

    // Cycle counter within the current interval.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (hold || tick) cnt <= '0;
        else                   cnt <= cnt + CNT_W'(1);
    end

    // Debt: add on expiry (saturating), subtract when a refresh is served.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            owed <= '0;
        end else if (tick && !take) begin
            if (owed < OW_W'(OWE_MAX)) owed <= owed + OW_W'(1);
        end else if (take && !tick) begin
            owed <= owed - OW_W'(1);
        end
    end

    p_owed_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= OW_W'(OWE_MAX));

    p_take_has_debt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (owed != '0));

endmodule

// File: rtl/rfs_seq.sv
// Refresh sequencer: decides when to request the grant, issue a refresh,
// wait out the gap, and walk the self refresh entry / hold / exit sequence.
// One shared down counter times both the post-refresh gap and the exit wait.
// Assumes gap_q and txsr_q are >= 1 (clamped by the top).
module rfs_seq
    import rfs_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int BURST_N = 8192,
    parameter int OW_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] gap_q,
    input  logic [CNT_W-1:0] txsr_q,
    input  logic             burst_q,
    input  logic [OW_W-1:0]  owed,
    input  logic             bank_idle_gnt,
    input  logic             sr_enter_req,
    input  logic             sr_exit_req,
    output rfs_state_e       state,
    output logic             take,
    output logic             hold,
    output logic             clr
);

    localparam int BL_W = $clog2(BURST_N + 1);

    rfs_state_e       nxt;
    rfs_state_e       pick;
    logic [CNT_W-1:0] wcnt;
    logic [BL_W-1:0]  burst_left;
    logic             sr_pend;
    logic             in_sr;
    logic             work;
    logic             act;
    logic             burst_load;
    logic             exit_done;

    assign in_sr      = (state == ST_SR_CMD) || (state == ST_SR_HOLD) || (state == ST_SR_EXIT);
    assign work       = (owed != '0) || (burst_left != '0);
    assign act        = work || sr_pend;
    assign pick       = work ? ST_ISSUE : ST_SR_CMD;
    assign burst_load = sr_enter_req && !sr_pend && !in_sr && burst_q;
    assign exit_done  = (state == ST_SR_EXIT) && (wcnt == '0);
    assign take       = (state == ST_ISSUE) && (burst_left == '0);
    assign hold       = in_sr || (burst_left != '0);
    assign clr        = burst_load || (state == ST_SR_CMD);

    // Next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:    if (act) nxt = ST_REQ;
            ST_REQ:     if (bank_idle_gnt) nxt = act ? pick : ST_IDLE;
            ST_ISSUE:   nxt = ST_WAIT;
            ST_WAIT:    if (wcnt == '0) nxt = !act ? ST_IDLE : (bank_idle_gnt ? pick : ST_REQ);
            ST_SR_CMD:  nxt = ST_SR_HOLD;
            ST_SR_HOLD: if (sr_exit_req) nxt = ST_SR_EXIT;
            ST_SR_EXIT: if (wcnt == '0) nxt = burst_q ? ST_REQ : ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Shared wait counter: gap after a refresh, quiet time after exit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wcnt <= '0;
        else if (state == ST_ISSUE)
            wcnt <= gap_q - CNT_W'(1);
        else if (state == ST_SR_HOLD && sr_exit_req)
            wcnt <= txsr_q - CNT_W'(1);
        else if ((state == ST_WAIT || state == ST_SR_EXIT) && wcnt != '0)
            wcnt <= wcnt - CNT_W'(1);
    end

    // Burst counter: loaded on an entry request and at the end of the exit wait.
    always_ff @(posedge clk) begin
        if (!rst_n)
            burst_left <= '0;
        else if (burst_load || (exit_done && burst_q))
            burst_left <= BL_W'(BURST_N);
        else if (state == ST_ISSUE && burst_left != '0)
            burst_left <= burst_left - BL_W'(1);
    end

    // Pending entry flag: set by a request outside self refresh, cleared on entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                      sr_pend <= 1'b0;
        else if (state == ST_SR_CMD)     sr_pend <= 1'b0;
        else if (sr_enter_req && !in_sr) sr_pend <= 1'b1;
    end

    // Assertion support: cycles since the last refresh, saturating.
    logic [CNT_W:0] since_iss;
    always_ff @(posedge clk) begin
        if (!rst_n)                since_iss <= '1;
        else if (state == ST_ISSUE) since_iss <= '0;
        else if (since_iss != '1)   since_iss <= since_iss + (CNT_W+1)'(1);
    end

    p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE || state == ST_SR_CMD) |-> (since_iss >= {1'b0, gap_q}));

    p_grant_before_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE || state == ST_SR_CMD) |-> $past(bank_idle_gnt));

endmodule

// File: rtl/rfs_pins.sv
// Pin decoder: maps the sequencer state onto the command strobes and clock
// enable. Purely combinational; assumes the state is a registered value.
module rfs_pins
    import rfs_pkg::*;
(
    input  rfs_state_e state,
    output pin_cmd_t   pins
);

    // State to pin pattern.
    always_comb begin
        case (state)
            ST_ISSUE:   pins = PINS_AREF;
            ST_SR_CMD:  pins = PINS_SREN;
            ST_SR_HOLD: pins = PINS_SLEEP;
            default:    pins = PINS_NOP;
        endcase
    end

endmodule

// File: rtl/sdram_refresh_sched.sv
// SDRAM refresh scheduler top. Captures the timing configuration while reset
// is low, clamps zero counts to one, and wires the interval timer, sequencer
// and pin decoder together. Assumes the main controller keeps all banks
// precharged for as long as it grants bank_idle_gnt.
module sdram_refresh_sched
    import rfs_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int OWE_MAX = 8,
    parameter int BURST_N = 8192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_interval,
    input  logic [CNT_W-1:0] cfg_trc,
    input  logic [CNT_W-1:0] cfg_trp,
    input  logic [CNT_W-1:0] cfg_txsr,
    input  logic             cfg_burst_en,
    input  logic             bank_idle_gnt,
    input  logic             sr_enter_req,
    input  logic             sr_exit_req,
    output logic             ref_req,
    output logic             busy,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic             sd_cke
);

    localparam int OW_W = $clog2(OWE_MAX + 1);

    logic [CNT_W-1:0] interval_q;
    logic [CNT_W-1:0] gap_q;
    logic [CNT_W-1:0] txsr_q;
    logic             burst_q;
    logic [CNT_W-1:0] gap_raw;
    logic [OW_W-1:0]  owed;
    logic             take;
    logic             hold;
    logic             clr;
    rfs_state_e       state;
    pin_cmd_t         pins;

    assign gap_raw = (cfg_trc > cfg_trp) ? cfg_trc : cfg_trp;

    // Configuration capture while reset is held; frozen afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            interval_q <= (cfg_interval == '0) ? CNT_W'(1) : cfg_interval;
            gap_q      <= (gap_raw == '0) ? CNT_W'(1) : gap_raw;
            txsr_q     <= (cfg_txsr == '0) ? CNT_W'(1) : cfg_txsr;
            burst_q    <= cfg_burst_en;
        end
    end

    rfs_interval #(.CNT_W(CNT_W), .OWE_MAX(OWE_MAX), .OW_W(OW_W)) u_interval (
        .clk        (clk),
        .rst_n      (rst_n),
        .interval_q (interval_q),
        .hold       (hold),
        .clr        (clr),
        .take       (take),
        .owed       (owed)
    );

    rfs_seq #(.CNT_W(CNT_W), .BURST_N(BURST_N), .OW_W(OW_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .gap_q         (gap_q),
        .txsr_q        (txsr_q),
        .burst_q       (burst_q),
        .owed          (owed),
        .bank_idle_gnt (bank_idle_gnt),
        .sr_enter_req  (sr_enter_req),
        .sr_exit_req   (sr_exit_req),
        .state         (state),
        .take          (take),
        .hold          (hold),
        .clr           (clr)
    );

    rfs_pins u_pins (
        .state (state),
        .pins  (pins)
    );

    assign sd_cs_n  = pins.cs_n;
    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;
    assign sd_cke   = pins.cke;
    assign ref_req  = (state == ST_REQ);
    assign busy     = (state != ST_IDLE);

    // Assertion support: clock enable of the previous cycle.
    logic cke_prev;
    always_ff @(posedge clk) begin
        if (!rst_n) cke_prev <= 1'b1;
        else        cke_prev <= sd_cke;
    end

    p_aref_after_cke_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n && sd_cke) |-> cke_prev);

    p_cke_held_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cke && !sr_exit_req) |=> !sd_cke);

    p_exit_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SR_EXIT) |-> (sd_cke && sd_ras_n && sd_cas_n && sd_we_n));

    p_busy_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req || !sd_ras_n) |-> busy);

endmodule

// File: tb/sdram_refresh_sched_tb.sv
// Testbench: seeded random configurations per round plus directed debt sizes.
module sdram_refresh_sched_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 16;
    localparam int BN         = 16;
    localparam int OMAX       = 8;
    localparam int MAX_CYC    = 150000;
    localparam int ROUNDS     = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg_interval, cfg_trc, cfg_trp, cfg_txsr;
    logic          cfg_burst_en;
    logic          bank_idle_gnt, sr_enter_req, sr_exit_req;
    logic          ref_req, busy, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke;

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic gnt_s = 1'b0;
    int mon_gap = 1;
    int mon_last = -100000;
    int bad_pins = 0, bad_gnt = 0, bad_busy = 0, bad_gap = 0;

    sdram_refresh_sched #(.CNT_W(CW), .OWE_MAX(OMAX), .BURST_N(BN)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_interval(cfg_interval), .cfg_trc(cfg_trc), .cfg_trp(cfg_trp),
        .cfg_txsr(cfg_txsr), .cfg_burst_en(cfg_burst_en),
        .bank_idle_gnt(bank_idle_gnt), .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req),
        .ref_req(ref_req), .busy(busy),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_cke(sd_cke)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc   <= cyc + 1;
        gnt_s <= bank_idle_gnt;
    end

    function automatic bit is_aref();
        return !sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n && sd_cke;
    endfunction
    function automatic bit is_sren();
        return !sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n && !sd_cke;
    endfunction
    function automatic bit is_nop();
        return !sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n && sd_cke;
    endfunction
    function automatic bit is_desel();
        return sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n && !sd_cke;
    endfunction
    function automatic int clamp1(int v);
        return (v == 0) ? 1 : v;
    endfunction
    function automatic int exp_gap(int trc, int trp);
        return clamp1((trc > trp) ? trc : trp);
    endfunction
    function automatic int exp_owed(int k);
        return (k > OMAX) ? OMAX : k;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_ref(output int c, input int lim);
        c = -1;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (is_aref()) begin
                c = cyc;
                break;
            end
        end
    endtask

    // Continuous pin, grant, busy and gap monitor (R2, R3, R4, R9).
    always @(negedge clk) begin
        if (!rst_n) begin
            mon_last = -100000;
        end else if (!done) begin
            if (sd_cke && !(is_aref() || is_nop())) bad_pins++;
            if (!sd_cke && !(is_sren() || is_desel())) bad_pins++;
            if (is_aref() && !gnt_s) bad_gnt++;
            if ((ref_req || is_aref() || is_sren()) && !busy) bad_busy++;
            if (is_aref() || is_sren()) begin
                if (cyc - mon_last < mon_gap + 1) bad_gap++;
                mon_last = cyc;
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic run_round(int r, int k);
        int ival, trc, trp, txsr, gap, tx, c0, c1, c2, c3, cnt, last, sbad, bad, quiet, hcyc;
        bit burst, found;
        ival  = 120 + int'($urandom % 181);
        trc   = (r == 0) ? 0 : int'($urandom % 7);
        trp   = (r == 0) ? 0 : int'($urandom % 7);
        txsr  = (r == 1) ? 0 : int'($urandom % 9);
        burst = (r % 2) == 1;
        gap   = exp_gap(trc, trp);
        tx    = clamp1(txsr);
        mon_gap = gap;

        rst_n = 1'b0; bank_idle_gnt = 1'b0; sr_enter_req = 1'b0; sr_exit_req = 1'b0;
        cfg_interval = CW'(ival); cfg_trc = CW'(trc); cfg_trp = CW'(trp);
        cfg_txsr = CW'(txsr); cfg_burst_en = burst;
        repeat (3) @(negedge clk);
        chk(!busy && !ref_req && sd_cke && is_nop(), "R10 reset outputs", int'(busy) + 2*int'(ref_req), 0);
        rst_n = 1'b1;
        // R11: disturb every configuration input after reset.
        cfg_interval = CW'(ival + 37); cfg_trc = CW'(trc + 5); cfg_trp = CW'(trp + 4);
        cfg_txsr = CW'(txsr + 6); cfg_burst_en = !burst;
        @(negedge clk);
        chk(!busy && !ref_req && is_nop(), "R10 idle after reset", int'(busy), 0);

        // R1 / R11: periodic spacing with grant held.
        bank_idle_gnt = 1'b1;
        wait_ref(c0, ival + 10);
        wait_ref(c1, ival + 10);
        wait_ref(c2, ival + 10);
        chk(c0 >= 0 && c1 - c0 == ival, "R1 interval spacing", c1 - c0, ival);
        chk(c2 - c1 == ival, "R11 spacing ignores later cfg", c2 - c1, ival);

        // R3 / R8: withhold the grant for k intervals.
        bank_idle_gnt = 1'b0;
        cnt = 0;
        for (int i = 0; i < k * ival; i++) begin
            @(negedge clk);
            if (is_aref()) cnt++;
        end
        chk(cnt == 0, "R3 no refresh without grant", cnt, 0);
        chk(ref_req == 1'b1, "R3 request raised", int'(ref_req), 1);
        bank_idle_gnt = 1'b1;
        cnt = 0; last = -1; sbad = 0;
        for (int i = 0; i < ival / 2; i++) begin
            @(negedge clk);
            if (is_aref()) begin
                if (last >= 0 && cyc - last != gap + 1) sbad++;
                last = cyc;
                cnt++;
            end
        end
        chk(cnt == exp_owed(k), "R8 owed refreshes", cnt, exp_owed(k));
        chk(sbad == 0, "R4 back-to-back spacing", sbad, 0);

        // R5 / R7: self refresh entry, launched right after a refresh.
        wait_ref(c3, ival + 10);
        sr_enter_req = 1'b1;
        @(negedge clk);
        sr_enter_req = 1'b0;
        cnt = is_aref() ? 1 : 0; last = -1; sbad = 0; found = 1'b0;
        for (int i = 0; i < (BN + 2) * (gap + 1) + 20; i++) begin
            @(negedge clk);
            if (is_sren()) begin
                found = 1'b1;
                break;
            end
            if (is_aref()) begin
                if (last >= 0 && cyc - last != gap + 1) sbad++;
                last = cyc;
                cnt++;
            end
        end
        chk(found, "R5 entry command", int'(found), 1);
        chk(cnt == (burst ? BN : 0), "R7 refreshes before entry", cnt, burst ? BN : 0);
        chk(sbad == 0, "R7 pre-entry burst spacing", sbad, 0);

        hcyc = 5 + int'($urandom % 30);
        bad = 0;
        for (int i = 0; i < hcyc; i++) begin
            @(negedge clk);
            if (sd_cke || !sd_cs_n || !busy) bad++;
        end
        chk(bad == 0, "R5 cke low and deselected while held", bad, 0);

        // R6 / R9: exit wait.
        sr_exit_req = 1'b1;
        @(negedge clk);
        sr_exit_req = 1'b0;
        chk(sd_cke == 1'b1, "R6 cke rises after exit request", int'(sd_cke), 1);
        quiet = 1; c0 = -1;
        for (int i = 0; i < tx + 10; i++) begin
            @(negedge clk);
            if (is_aref()) begin
                c0 = cyc;
                break;
            end
            if (!busy) break;
            quiet++;
        end
        chk(quiet == (burst ? tx + 1 : tx), "R6 quiet cycles after exit", quiet, burst ? tx + 1 : tx);

        if (burst) begin
            cnt = (c0 >= 0) ? 1 : 0; last = c0; sbad = 0; c1 = -1;
            for (int i = 0; i < (BN + 2) * (gap + 1) + 20; i++) begin
                @(negedge clk);
                if (!busy) begin
                    c1 = cyc;
                    break;
                end
                if (is_aref()) begin
                    if (cyc - last != gap + 1) sbad++;
                    last = cyc;
                    cnt++;
                end
            end
            chk(cnt == BN && sbad == 0, "R7 post-exit burst", cnt, BN);
            chk(c1 - last == gap + 1, "R9 busy falls after last wait", c1 - last, gap + 1);
        end
        repeat (5) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int r = 0; r < ROUNDS; r++) begin
            int k;
            k = (r == 0) ? 11 : (r == 1) ? 1 : (r == 2) ? 8 : 2 + int'($urandom % 9);
            run_round(r, k);
        end
        done = 1'b1;
        chk(bad_pins == 0, "R2 pin encodings", bad_pins, 0);
        chk(bad_gnt == 0, "R3 refresh only after grant", bad_gnt, 0);
        chk(bad_gap == 0, "R4 minimum gap", bad_gap, 0);
        chk(bad_busy == 0, "R9 busy coverage", bad_busy, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, MAX_CYC);
            summary();
            $finish;
        end
    end

endmodule